// File: doc/BRIEF.md
# Four-channel interval timer

A register-mapped peripheral that holds four independent down-counters. Each channel is armed by writing a reload value and then setting its enable bit. While enabled, the channel counts one step per clock. When it reaches zero it raises its pending flag and starts again from the reload value. The period of each channel is therefore reload + 1 clock cycles.

Software reads and writes through a generic single-cycle register port: an address, a write strobe, write data, and combinational read data. Three shared registers collect the per-channel interrupt masks, pending flags and enables. A single level-sensitive interrupt line is asserted while any pending flag is unmasked. Pending flags are cleared by writing ones to them.

Top module: `interval_timer_4ch`

## Requirements
- R1: After reset, all writable registers, pending flags and counters read as zero, and `irq_o` is low.
- R2: The register at 0x00 always reads 0x5449_0001 and ignores writes. The register at 0x10 always reads the channel count (4) and ignores writes.
- R3: Channel n (n = 0..3) has three registers. Its control register is at 0x20+16n, and only bit 0 (count width) and bit 3 (clock source) are stored; all other bits read zero. Its reload register is at 0x24+16n and is fully read/write. Its counter is at 0x28+16n and is read-only.
- R4: In the interrupt-mask (0x14), pending (0x18) and enable (0x1C) registers, channel n owns bit 4n. All other bits read zero and ignore writes.
- R5: A write that changes a channel's enable bit from 0 to 1 loads its counter from its reload register. A write of 1 to an enable bit that is already 1 does not reload. While a channel is disabled, its counter holds its value.
- R6: An enabled channel decrements each cycle. On a cycle where its counter is zero, it sets its pending bit and reloads instead of decrementing. The first pending bit therefore appears reload + 1 cycles after enable.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R8: A clear and a new expiry on the same channel in the same cycle leave the pending bit set.
- R9: `irq_o` is high exactly when some channel has both its pending bit and its mask bit set.
- R10: Clearing and then setting the enable bit of a running channel restarts its countdown from the reload value.
- R11: Unmapped addresses (for example 0x0C, 0x2C and 0x60) read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; also the count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can land on the same edge: a software write-one-to-clear to a pending bit, and a hardware expiry of the same channel. The bench forces this collision. It lets channel 0 run until its counter reads zero, then issues the clear write so that the write edge is exactly the expiry edge. The pending bit must stay set and the counter must show the reload value. A second clear, one cycle later, must then succeed.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int BIT_STRIDE = 4;

  localparam logic [ADDR_W-1:0] A_ID   = 8'h00;
  localparam logic [ADDR_W-1:0] A_CFG  = 8'h10;
  localparam logic [ADDR_W-1:0] A_MASK = 8'h14;
  localparam logic [ADDR_W-1:0] A_PEND = 8'h18;
  localparam logic [ADDR_W-1:0] A_ENAB = 8'h1C;
  localparam logic [3:0]        CH_BASE_NIB = 4'h2;

  typedef enum logic [1:0] {
    CH_CTRL   = 2'd0,
    CH_RELOAD = 2'd1,
    CH_COUNT  = 2'd2,
    CH_NONE   = 2'd3
  } ch_reg_e;

  localparam int CTRL_WIDTH_BIT = 0;
  localparam int CTRL_SRC_BIT   = 3;
endpackage

// File: rtl/ivt_channel.sv
module ivt_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = en_i && (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= reload_i;
    else if (en_i) begin
      if (cnt_q == '0) cnt_q <= reload_i;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(reload_i));
  // R5
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_q));
  // R6
  wrap_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !load_i) |=> cnt_q == $past(reload_i));
endmodule

// File: rtl/ivt_status.sv
module ivt_status #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0] pend_q;

  // expiry has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    // R8
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[n] |=> pend_q[n]);
    // R7
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[n] && !set_i[n]) |=> !pend_q[n]);
  end
endmodule

// File: rtl/interval_timer_4ch.sv
module interval_timer_4ch
  import ivt_pkg::*;
#(
  parameter int          NUM_CH   = 4,
  parameter int          CNT_W    = 32,
  parameter logic [31:0] ID_VALUE = 32'h5449_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int LAST_BIT = BIT_STRIDE * (NUM_CH - 1);

  logic [NUM_CH-1:0] mask_q, enab_q, pend, expire, load, clr;
  logic [NUM_CH-1:0] ctrl_w_q, ctrl_s_q;
  logic [CNT_W-1:0]  reload_q [NUM_CH];
  logic [CNT_W-1:0]  cnt      [NUM_CH];
  logic [NUM_CH-1:0] ch_hit;
  logic [NUM_CH-1:0] wdata_bits;
  ch_reg_e           ch_reg;
  logic              wr_mask, wr_pend, wr_enab;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign ch_reg  = ch_reg_e'(addr_i[3:2]);
  assign wr_mask = wr_en_i && (addr_i == A_MASK);
  assign wr_pend = wr_en_i && (addr_i == A_PEND);
  assign wr_enab = wr_en_i && (addr_i == A_ENAB);

  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      wdata_bits[n] = wdata_i[BIT_STRIDE*n];
      ch_hit[n]     = (addr_i[7:4] == CH_BASE_NIB + 4'(n)) && (addr_i[1:0] == 2'b00);
      load[n]       = wr_enab && wdata_bits[n] && !enab_q[n];
      clr[n]        = wr_pend && wdata_bits[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      enab_q   <= '0;
      ctrl_w_q <= '0;
      ctrl_s_q <= '0;
      for (int n = 0; n < NUM_CH; n++) reload_q[n] <= '0;
    end else if (wr_en_i) begin
      if (wr_mask) mask_q <= wdata_bits;
      if (wr_enab) enab_q <= wdata_bits;
      for (int n = 0; n < NUM_CH; n++) begin
        if (ch_hit[n] && ch_reg == CH_CTRL) begin
          ctrl_w_q[n] <= wdata_i[CTRL_WIDTH_BIT];
          ctrl_s_q[n] <= wdata_i[CTRL_SRC_BIT];
        end
        if (ch_hit[n] && ch_reg == CH_RELOAD) reload_q[n] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    ivt_channel #(.CNT_W(CNT_W)) i_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (enab_q[n]),
      .load_i   (load[n]),
      .reload_i (reload_q[n]),
      .cnt_o    (cnt[n]),
      .expire_o (expire[n])
    );
  end

  ivt_status #(.NUM_CH(NUM_CH)) i_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .clr_i  (clr),
    .pend_o (pend)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_ID:    rdata_o = ID_VALUE;
      A_CFG:   rdata_o = DATA_W'(NUM_CH);
      A_MASK:  for (int n = 0; n < NUM_CH; n++) rdata_o[BIT_STRIDE*n] = mask_q[n];
      A_PEND:  for (int n = 0; n < NUM_CH; n++) rdata_o[BIT_STRIDE*n] = pend[n];
      A_ENAB:  for (int n = 0; n < NUM_CH; n++) rdata_o[BIT_STRIDE*n] = enab_q[n];
      default: begin
        for (int n = 0; n < NUM_CH; n++) begin
          if (ch_hit[n]) begin
            case (ch_reg)
              CH_CTRL: begin
                rdata_o[CTRL_WIDTH_BIT] = ctrl_w_q[n];
                rdata_o[CTRL_SRC_BIT]   = ctrl_s_q[n];
              end
              CH_RELOAD: rdata_o[CNT_W-1:0] = reload_q[n];
              CH_COUNT:  rdata_o[CNT_W-1:0] = cnt[n];
              default:   rdata_o = '0;
            endcase
          end
        end
      end
    endcase
  end

  assign irq_o = |(pend & mask_q);

  initial assert (LAST_BIT < DATA_W);

  // R9
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(wr_en_i) || $past(|expire)));
endmodule

// File: tb/test_interval_timer_4ch.sv
module test_interval_timer_4ch;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  interval_timer_4ch i_interval_timer_4ch (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic test_reset;
    rd_chk("R2 id", 8'h00, 32'h5449_0001);
    rd_chk("R2 cfg", 8'h10, 32'd4);
    rd_chk("R1 mask", 8'h14, 32'h0);
    rd_chk("R1 pend", 8'h18, 32'h0);
    rd_chk("R1 enab", 8'h1C, 32'h0);
    rd_chk("R1 ctrl0", 8'h20, 32'h0);
    rd_chk("R1 reload3", 8'h54, 32'h0);
    rd_chk("R1 cnt1", 8'h38, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic test_map;
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R3 ctrl2 bits", 8'h40, 32'h9);
    wr(8'h54, 32'hDEAD_BEEF);
    rd_chk("R3 reload3", 8'h54, 32'hDEAD_BEEF);
    wr(8'h58, 32'h0000_0123);
    rd_chk("R3 cnt3 read-only", 8'h58, 32'h0);
    wr(8'h00, 32'h0000_FFFF);
    rd_chk("R2 id write ignored", 8'h00, 32'h5449_0001);
    wr(8'h10, 32'h0000_00FF);
    rd_chk("R2 cfg write ignored", 8'h10, 32'd4);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R11 0x0C", 8'h0C, 32'h0);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd_chk("R11 0x2C", 8'h2C, 32'h0);
    wr(8'h60, 32'hFFFF_FFFF);
    rd_chk("R11 0x60", 8'h60, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk("R4 mask spacing", 8'h14, 32'h0000_1111);
    wr(8'h14, 32'h0);
    rd_chk("R4 enab untouched", 8'h1C, 32'h0);
  endtask

  task automatic test_count;
    wr(8'h24, 32'd3);
    wr(8'h1C, 32'h1);
    rd_chk("R5 load on enable", 8'h28, 32'd3);
    tick(2);
    rd_chk("R6 decrement", 8'h28, 32'd1);
    tick(1);
    rd_chk("R6 zero cnt", 8'h28, 32'd0);
    rd_chk("R6 no early pend", 8'h18, 32'h0);
    tick(1);
    rd_chk("R6 pend after reload+1", 8'h18, 32'h1);
    rd_chk("R6 reloaded", 8'h28, 32'd3);
    chk("R9 masked irq", {31'b0, irq_o}, 32'h0);
    wr(8'h1C, 32'h0);
    rd_chk("R5 off cnt", 8'h28, 32'd2);
    tick(3);
    rd_chk("R5 hold while off", 8'h28, 32'd2);
    wr(8'h14, 32'h1);
    chk("R9 irq on", {31'b0, irq_o}, 32'h1);
    wr(8'h18, 32'h0);
    rd_chk("R7 zero write keeps", 8'h18, 32'h1);
    wr(8'h18, 32'hFFFF_FFFF);
    rd_chk("R7 clear all", 8'h18, 32'h0);
    chk("R9 irq off", {31'b0, irq_o}, 32'h0);
    wr(8'h14, 32'h0);
  endtask

  task automatic test_restart;
    wr(8'h1C, 32'h1);
    rd_chk("R5 reload on rise", 8'h28, 32'd3);
    tick(1);
    rd_chk("R10 running", 8'h28, 32'd2);
    wr(8'h1C, 32'h0);
    wr(8'h1C, 32'h1);
    rd_chk("R10 restart", 8'h28, 32'd3);
    wr(8'h1C, 32'h1);
    rd_chk("R5 no reload when already on", 8'h28, 32'd2);
    wr(8'h1C, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
  endtask

  task automatic test_collision;
    wr(8'h1C, 32'h1);
    tick(4);
    rd_chk("R8 setup pend", 8'h18, 32'h1);
    tick(3);
    rd_chk("R8 setup zero", 8'h28, 32'd0);
    wr(8'h18, 32'h1);
    rd_chk("R8 expiry wins", 8'h18, 32'h1);
    rd_chk("R8 reloaded", 8'h28, 32'd3);
    wr(8'h18, 32'h1);
    rd_chk("R7 later clear", 8'h18, 32'h0);
    wr(8'h1C, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
  endtask

  task automatic test_multi;
    wr(8'h34, 32'd5);
    wr(8'h44, 32'd2);
    wr(8'h1C, 32'h0000_0110);
    rd_chk("R3 cnt1", 8'h38, 32'd5);
    rd_chk("R3 cnt2", 8'h48, 32'd2);
    tick(2);
    rd_chk("R4 none yet", 8'h18, 32'h0);
    tick(1);
    rd_chk("R4 ch2 bit 8", 8'h18, 32'h0000_0100);
    tick(3);
    rd_chk("R4 ch1 bit 4", 8'h18, 32'h0000_0110);
    chk("R9 all masked", {31'b0, irq_o}, 32'h0);
    wr(8'h14, 32'h0000_0010);
    chk("R9 ch1 irq", {31'b0, irq_o}, 32'h1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset;
    test_map;
    test_count;
    test_restart;
    test_collision;
    test_multi;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule